// File: doc/BRIEF.md
# AU-4 Pointer Justification Generator

This block is the transmit-side pointer processor for a VC-4 carried in an AU-4 with a floating offset. It watches the fill level of the payload buffer that sits between the VC-4 clock and the line frame clock. At each frame boundary it chooses one of four actions: send the pointer unchanged, increment it (positive justification), decrement it (negative justification), or load a new value supplied from outside. It produces the two pointer bytes for the frame. It also produces two byte-slot selects. One tells the frame assembler that the three H3 slots carry payload. The other tells it that the three slots right after H3 are left empty.

A fill level above the high mark asks for more payload per frame, which is a decrement. A fill level below the low mark asks for less, which is an increment. Requests that arrive during the hold-off after an adjustment or a load are kept and carried out later. Frame assembly and all other overhead bytes belong to other blocks.

Top module: `au4_ptr_justifier`

## Requirements
- R1: The pointer stays within 0 to 782. An increment from 782 gives 0, and a decrement from 0 gives 782.
- R2: When a frame starts with the fill level above HI_MARK (40) and no hold-off is active, that frame is a negative justification. `h3_data_sel` is 1 and `post_h3_stuff` is 0. The line word is the old pointer with its D bits (bits 8,6,4,2,0, mask 0x155) inverted. `cur_ptr` becomes the old value minus one, and that value is sent plainly from the next frame.
- R3: When a frame starts with the fill level below LO_MARK (24) and no hold-off is active, that frame is a positive justification. `post_h3_stuff` is 1 and `h3_data_sel` is 0. The line word is the old pointer with its I bits (bits 9,7,5,3,1, mask 0x2AA) inverted. `cur_ptr` becomes the old value plus one, and that value is sent plainly from the next frame.
- R4: A fill level from LO_MARK to HI_MARK inclusive makes no request. With nothing pending, the frame sends the current pointer plainly and both selects are 0.
- R5: After an adjustment or a valid load in frame N, frames N+1 to N+3 send the pointer plainly. A request seen during those frames stays pending. It is carried out at frame N+4 even if the fill level has returned to the normal band.
- R6: A newer request replaces an opposite pending request. Only the most recent direction is carried out.
- R7: A load with `load_ptr` at most 782 takes priority over justification. In that same frame it sends the new value plainly with the new-data flag set to 1001. It clears any pending request and starts the hold-off of R5. A load value above 782 is ignored entirely.
- R8: `h1_byte` is {flag[3:0], 2'b10, word[9:8]} and `h2_byte` is word[7:0]. The flag is 0110 in every frame except a valid load frame.
- R9: All outputs change only on the clock edge where `frame_tick` is 1. They are visible the cycle after that edge and hold until the next such edge.
- R10: After reset the pointer is INIT_PTR (522), `h1_byte` is 0x6A, `h2_byte` is 0x0A, both selects are 0, nothing is pending and no hold-off is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe marking the frame decision point |
| fill_level | input | FILL_W | Payload buffer occupancy, sampled with frame_tick |
| load_en | input | 1 | Request to load an arbitrary pointer, sampled with frame_tick |
| load_ptr | input | 10 | Pointer value to load |
| h1_byte | output | 8 | First pointer byte for the frame |
| h2_byte | output | 8 | Second pointer byte for the frame |
| h3_data_sel | output | 1 | The three H3 slots carry payload this frame |
| post_h3_stuff | output | 1 | The three slots after H3 are left empty this frame |
| cur_ptr | output | 10 | Pointer value now in effect |

## Verification
Each decision is registered once, on the edge where `frame_tick` is high. The bytes, both selects and `cur_ptr` for a frame are therefore due exactly one cycle after the strobe. The bench drives the strobe on a falling edge, removes it on the next falling edge and reads all outputs at that point, half a cycle after the capturing edge. Hold-off and pending behaviour is counted in frames rather than cycles. The bench checks frames N+1 to N+4 one by one, and it checks again mid-frame that nothing has moved between strobes.

// File: rtl/au4_ptr_pkg.sv
package au4_ptr_pkg;

  localparam int unsigned PTR_W   = 10;
  localparam int unsigned PTR_MAX = 782;

  localparam logic [PTR_W-1:0] I_MASK   = 10'h2AA;
  localparam logic [PTR_W-1:0] D_MASK   = 10'h155;
  localparam logic [3:0]       FLAG_RUN = 4'b0110;
  localparam logic [3:0]       FLAG_NEW = 4'b1001;
  localparam logic [1:0]       SS_AU4   = 2'b10;

  typedef enum logic [1:0] {REQ_NONE, REQ_POS, REQ_NEG} req_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_INC, ACT_DEC, ACT_LOAD} act_e;

  function automatic logic [PTR_W-1:0] ptr_up(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(PTR_MAX)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_down(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(PTR_MAX) : p - 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] line_word(input logic [PTR_W-1:0] p, input act_e a);
    case (a)
      ACT_INC: return p ^ I_MASK;
      ACT_DEC: return p ^ D_MASK;
      default: return p;
    endcase
  endfunction

endpackage

// File: rtl/au4_fill_classifier.sv
module au4_fill_classifier
  import au4_ptr_pkg::*;
#(
  parameter int unsigned FILL_W  = 6,
  parameter int unsigned HI_MARK = 40,
  parameter int unsigned LO_MARK = 24
) (
  input  logic [FILL_W-1:0] fill,
  output req_e              req
);
  localparam logic [FILL_W-1:0] HI_V = FILL_W'(HI_MARK);
  localparam logic [FILL_W-1:0] LO_V = FILL_W'(LO_MARK);

  always_comb begin
    if (fill > HI_V)      req = REQ_NEG;
    else if (fill < LO_V) req = REQ_POS;
    else                  req = REQ_NONE;
  end

  always_comb begin
    AST_REQ_BAND: assert (!(req != REQ_NONE && fill >= LO_V && fill <= HI_V)); // R4
  end
endmodule

// File: rtl/au4_adj_scheduler.sv
module au4_adj_scheduler
  import au4_ptr_pkg::*;
#(
  parameter int unsigned HOLD_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  req_e req_now,
  input  logic load_ok,
  output act_e act
);
  localparam int unsigned HW = $clog2(HOLD_FRAMES + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD_FRAMES);

  logic [HW-1:0] hold_q;
  req_e          pend_q;
  req_e          eff_req;
  logic          act_fire;

  assign eff_req  = (req_now != REQ_NONE) ? req_now : pend_q;

  always_comb begin
    act = ACT_NONE;
    if (frame_tick) begin
      if (load_ok)                    act = ACT_LOAD;
      else if (hold_q != '0)          act = ACT_NONE;
      else if (eff_req == REQ_POS)    act = ACT_INC;
      else if (eff_req == REQ_NEG)    act = ACT_DEC;
    end
  end

  assign act_fire = (act != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= REQ_NONE;
    end else if (frame_tick) begin
      if (act_fire) begin
        hold_q <= HOLD_V;
        pend_q <= REQ_NONE;
      end else begin
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
        if (req_now != REQ_NONE) pend_q <= req_now;
      end
    end
  end

  // Independent frame-gap counter for the spacing check
  logic [HW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= HOLD_V;
    else if (frame_tick) begin
      if (act_fire)             gap_q <= '0;
      else if (gap_q != HOLD_V) gap_q <= gap_q + 1'b1;
    end
  end

  AST_ADJ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_INC || act == ACT_DEC) |-> gap_q == HOLD_V); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && load_ok) |-> act == ACT_LOAD); // R7
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> pend_q == REQ_NONE); // R6
endmodule

// File: rtl/au4_ptr_word_gen.sv
module au4_ptr_word_gen
  import au4_ptr_pkg::*;
#(
  parameter int unsigned INIT_PTR = 522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  act_e             act,
  input  logic [PTR_W-1:0] load_ptr,
  output logic [7:0]       h1,
  output logic [7:0]       h2,
  output logic             h3_data,
  output logic             post_stuff,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] INIT_V = PTR_W'(INIT_PTR);

  logic [PTR_W-1:0] ptr_q, word_q;
  logic [3:0]       flag_q;
  logic             h3_q, stuff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= INIT_V;
      word_q  <= INIT_V;
      flag_q  <= FLAG_RUN;
      h3_q    <= 1'b0;
      stuff_q <= 1'b0;
    end else if (frame_tick) begin
      flag_q  <= FLAG_RUN;
      h3_q    <= 1'b0;
      stuff_q <= 1'b0;
      word_q  <= line_word(ptr_q, act);
      case (act)
        ACT_INC: begin
          ptr_q   <= ptr_up(ptr_q);
          stuff_q <= 1'b1;
        end
        ACT_DEC: begin
          ptr_q <= ptr_down(ptr_q);
          h3_q  <= 1'b1;
        end
        ACT_LOAD: begin
          ptr_q  <= load_ptr;
          word_q <= load_ptr;
          flag_q <= FLAG_NEW;
        end
        default: ;
      endcase
    end
  end

  assign h1         = {flag_q, SS_AU4, word_q[9:8]};
  assign h2         = word_q[7:0];
  assign h3_data    = h3_q;
  assign post_stuff = stuff_q;
  assign ptr        = ptr_q;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(PTR_MAX)); // R1
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(h3_q && stuff_q)); // R2
  AST_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(h1) && $stable(h2) && $stable(ptr_q))); // R9
  AST_FLAG_ON_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (h3_q || stuff_q) |-> h1[7:4] == FLAG_RUN); // R8
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && act == ACT_INC && ptr_q == PTR_W'(PTR_MAX)) |=> ptr_q == '0); // R1
endmodule

// File: rtl/au4_ptr_justifier.sv
module au4_ptr_justifier
  import au4_ptr_pkg::*;
#(
  parameter int unsigned FILL_W      = 6,
  parameter int unsigned HI_MARK     = 40,
  parameter int unsigned LO_MARK     = 24,
  parameter int unsigned HOLD_FRAMES = 3,
  parameter int unsigned INIT_PTR    = 522
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [FILL_W-1:0] fill_level,
  input  logic              load_en,
  input  logic [9:0]        load_ptr,
  output logic [7:0]        h1_byte,
  output logic [7:0]        h2_byte,
  output logic              h3_data_sel,
  output logic              post_h3_stuff,
  output logic [9:0]        cur_ptr
);
  req_e req_now;
  act_e act;
  logic load_ok;

  assign load_ok = load_en && (load_ptr <= PTR_W'(PTR_MAX));

  au4_fill_classifier #(.FILL_W(FILL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_class (
    .fill (fill_level),
    .req  (req_now)
  );

  au4_adj_scheduler #(.HOLD_FRAMES(HOLD_FRAMES)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .req_now    (req_now),
    .load_ok    (load_ok),
    .act        (act)
  );

  au4_ptr_word_gen #(.INIT_PTR(INIT_PTR)) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .act        (act),
    .load_ptr   (load_ptr),
    .h1         (h1_byte),
    .h2         (h2_byte),
    .h3_data    (h3_data_sel),
    .post_stuff (post_h3_stuff),
    .ptr        (cur_ptr)
  );

  AST_LOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && load_ok) |=> (h1_byte[7:4] == FLAG_NEW && cur_ptr == $past(load_ptr))); // R7
  AST_BAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && load_en && !load_ok) |=> h1_byte[7:4] == FLAG_RUN); // R7
endmodule

// File: tb/tb_au4_ptr_justifier.sv
module tb_au4_ptr_justifier;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [5:0] fill_level = 6'd32;
  logic       load_en = 1'b0;
  logic [9:0] load_ptr = '0;
  logic [7:0] h1_byte, h2_byte;
  logic       h3_data_sel, post_h3_stuff;
  logic [9:0] cur_ptr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  au4_ptr_justifier dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .fill_level(fill_level),
    .load_en(load_en), .load_ptr(load_ptr), .h1_byte(h1_byte), .h2_byte(h2_byte),
    .h3_data_sel(h3_data_sel), .post_h3_stuff(post_h3_stuff), .cur_ptr(cur_ptr)
  );

  localparam logic [3:0] RUN = 4'b0110;
  localparam logic [3:0] NEW = 4'b1001;

  // Bench-side restatement of the line format
  function automatic logic [9:0] flip_i(input logic [9:0] p);
    logic [9:0] r = p;
    for (int b = 1; b < 10; b += 2) r[b] = ~p[b];
    return r;
  endfunction
  function automatic logic [9:0] flip_d(input logic [9:0] p);
    logic [9:0] r = p;
    for (int b = 0; b < 10; b += 2) r[b] = ~p[b];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [3:0] flag, input logic [9:0] word,
                     input logic h3, input logic st, input logic [9:0] ptr);
    logic [7:0] e1, e2;
    e1 = {flag, 2'b10, word[9:8]};
    e2 = word[7:0];
    n_chk++;
    if (h1_byte !== e1 || h2_byte !== e2 || h3_data_sel !== h3 ||
        post_h3_stuff !== st || cur_ptr !== ptr) begin
      n_bad++;
      $display("FAIL %s: got h1=%h h2=%h h3=%b st=%b ptr=%0d exp h1=%h h2=%h h3=%b st=%b ptr=%0d",
               tag, h1_byte, h2_byte, h3_data_sel, post_h3_stuff, cur_ptr, e1, e2, h3, st, ptr);
    end
  endtask

  // One frame: strobe captured at the posedge between two negedges
  task automatic frame(input logic [5:0] fill, input logic ld, input logic [9:0] lv);
    @(negedge clk);
    fill_level = fill; load_en = ld; load_ptr = lv; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0; load_en = 1'b0;
  endtask

  task automatic idle_check(input string tag);
    logic [7:0] a1, a2;
    logic [9:0] ap;
    a1 = h1_byte; a2 = h2_byte; ap = cur_ptr;
    fill_level = 6'd2;
    repeat (4) @(negedge clk);
    n_chk++;
    if (h1_byte !== a1 || h2_byte !== a2 || cur_ptr !== ap) begin
      n_bad++;
      $display("FAIL %s: mid-frame change h1=%h h2=%h ptr=%0d exp h1=%h h2=%h ptr=%0d",
               tag, h1_byte, h2_byte, cur_ptr, a1, a2, ap);
    end
  endtask

  task automatic t_reset;
    chk("R10 reset", RUN, 10'd522, 0, 0, 10'd522);
    n_chk++;
    if (h1_byte !== 8'h6A || h2_byte !== 8'h0A) begin
      n_bad++;
      $display("FAIL R10 reset bytes: got %h %h exp 6a 0a", h1_byte, h2_byte);
    end
  endtask

  task automatic t_normal_and_neg;
    frame(6'd32, 0, 0); chk("R4 normal", RUN, 10'd522, 0, 0, 10'd522);
    idle_check("R9 stable");
    frame(6'd50, 0, 0); chk("R2 negative", RUN, flip_d(10'd522), 1, 0, 10'd521);
  endtask

  task automatic t_hold_pending;
    frame(6'd10, 0, 0); chk("R5 hold1", RUN, 10'd521, 0, 0, 10'd521);
    frame(6'd32, 0, 0); chk("R5 hold2", RUN, 10'd521, 0, 0, 10'd521);
    frame(6'd32, 0, 0); chk("R5 hold3", RUN, 10'd521, 0, 0, 10'd521);
    frame(6'd32, 0, 0); chk("R3 pending positive", RUN, flip_i(10'd521), 0, 1, 10'd522);
  endtask

  task automatic t_override;
    frame(6'd50, 0, 0); chk("R6 hold1", RUN, 10'd522, 0, 0, 10'd522);
    frame(6'd10, 0, 0); chk("R6 hold2", RUN, 10'd522, 0, 0, 10'd522);
    frame(6'd32, 0, 0); chk("R6 hold3", RUN, 10'd522, 0, 0, 10'd522);
    frame(6'd32, 0, 0); chk("R6 latest wins", RUN, flip_i(10'd522), 0, 1, 10'd523);
    for (int k = 0; k < 3; k++) begin
      frame(6'd32, 0, 0); chk("R8 plain", RUN, 10'd523, 0, 0, 10'd523);
    end
  endtask

  task automatic t_load_and_wrap;
    frame(6'd50, 1, 10'd782); chk("R7 load", NEW, 10'd782, 0, 0, 10'd782);
    for (int k = 0; k < 4; k++) begin
      frame(6'd32, 0, 0); chk("R7 pending cleared", RUN, 10'd782, 0, 0, 10'd782);
    end
    frame(6'd10, 0, 0); chk("R1 inc at 782", RUN, flip_i(10'd782), 0, 1, 10'd0);
    frame(6'd32, 0, 0); chk("R1 wrap to 0", RUN, 10'd0, 0, 0, 10'd0);
    frame(6'd32, 0, 0); chk("R5 hold", RUN, 10'd0, 0, 0, 10'd0);
    frame(6'd32, 0, 0); chk("R5 hold", RUN, 10'd0, 0, 0, 10'd0);
    frame(6'd50, 0, 0); chk("R1 dec at 0", RUN, 10'h155, 1, 0, 10'd782);
    frame(6'd32, 0, 0); chk("R1 wrap to 782", RUN, 10'd782, 0, 0, 10'd782);
  endtask

  task automatic t_bad_load_and_marks;
    frame(6'd32, 1, 10'd900); chk("R7 bad load ignored", RUN, 10'd782, 0, 0, 10'd782);
    frame(6'd32, 0, 0); chk("R5 hold", RUN, 10'd782, 0, 0, 10'd782);
    frame(6'd40, 0, 0); chk("R4 at high mark", RUN, 10'd782, 0, 0, 10'd782);
    frame(6'd24, 0, 0); chk("R4 at low mark", RUN, 10'd782, 0, 0, 10'd782);
    frame(6'd41, 0, 0); chk("R2 just above mark", RUN, flip_d(10'd782), 1, 0, 10'd781);
    frame(6'd23, 0, 0); chk("R5 held after dec", RUN, 10'd781, 0, 0, 10'd781);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_and_neg();
    t_hold_pending();
    t_override();
    t_load_and_wrap();
    t_bad_load_and_marks();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule